// File: doc/BRIEF.md
# Single-Wire Target Speed Detector

This block works out the clock rate of a target device that shares one open-drain debug wire with the host. On a start pulse it releases the wire and waits for the pull-up to bring it high. It then drives a long low request pulse, drives the wire high for a short time, and only then lets go. The target answers with a low pulse whose width is a fixed number of its own clock cycles. The block timestamps the falling and rising edges of that answer and converts the width to 60 MHz-equivalent ticks.

The converted width is checked against two ascending threshold tables, one of 20 entries for the transmit profile and one of 16 entries for the receive profile. Each table is searched from the top entry down, and the first threshold that the width meets or exceeds gives that profile's index. Two delay counts are also derived from the width; the bit engines later use them to wait about 64 and about 150 target cycles. All results stay stable until the next start pulse. The bit-level transmit and receive engines are not part of this block.

Top module: `sd_detector`

## Requirements
- R1: After start, the block releases the wire (`line_oe`=0) and waits for the wire to read high. If it stays low for more than `hi_timeout` cycles, the block finishes with `err`=4.
- R2: The request is `line_oe`=1 with `line_out`=0 for exactly REQ_CYCLES clocks. It is followed by exactly HI_CYCLES clocks of `line_oe`=1 with `line_out`=1, and then the wire is released. The wire is never released straight from driving low.
- R3: `sync_len` equals the number of clocks between the answer's falling edge and its rising edge, multiplied by 60/CLK_MHZ (10 by default).
- R4: If no falling edge arrives within `resp_timeout` cycles of release, the block finishes with `err`=1, `sync_len`=0 and `speed_valid`=0.
- R5: If the falling edge arrives but the rising edge does not come within the same `resp_timeout` budget, the block finishes with `err`=2.
- R6: `tx_idx` is the highest i in 0..19 whose transmit threshold is at or below `sync_len`. The transmit thresholds are 914, 1129, 1335, 1541, 1747, 1952, 2157, 2465, 2877, 3288, 3800, 4418, 5136, 6059, 7189, 8524, 10066, 11814, 13867 and 16988.
- R7: `rx_idx` is the highest i in 0..15 whose receive threshold is at or below `sync_len`. The receive thresholds are 853, 1101, 1347, 1592, 1837, 2202, 2694, 3303, 4042, 4897, 5998, 7346, 9055, 11257, 13952 and 17919.
- R8: The block finishes with `err`=3, `speed_valid`=0 and `tx_idx`, `rx_idx`, `wait64` and `wait150` all zero, while `sync_len` still holds the measured length, in either of these cases:
  - a table has no threshold at or below `sync_len`;
  - the selected entry is the last one in its table (index 19 for transmit, 15 for receive).
- R9: On success, `wait64` = `sync_len`/(6·60/CLK_MHZ) − 6 and `wait150` = `sync_len`/⌊384·(60/CLK_MHZ)/150⌋ − 7. With the defaults the divisors are 60 and 25.
- R10: An accepted start clears `done` and `speed_valid` on the next clock. Once `done`=1, every output holds its value, and the wire stays released, whatever the wire does, until the next start.
- R11: After reset, `line_oe`, `done`, `speed_valid` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, CLK_MHZ nominal |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a measurement (ignored while busy) |
| line_in | input | 1 | Wire level as read back |
| hi_timeout | input | TW | Cycle limit for the released wire to read high |
| resp_timeout | input | TW | Cycle budget for the target's answer |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Level driven when enabled |
| sync_len | output | LW | Answer width in 60 MHz ticks |
| tx_idx | output | 5 | Transmit profile index |
| rx_idx | output | 4 | Receive profile index |
| wait64 | output | LW | Delay count for about 64 target cycles |
| wait150 | output | LW | Delay count for about 150 target cycles |
| speed_valid | output | 1 | Measurement succeeded |
| done | output | 1 | Measurement finished (held) |
| err | output | 3 | 0 ok, 1 no falling edge, 2 no rising edge, 3 out of range, 4 wire stuck low |

## Verification
The hardest cases to reach are answers whose width lands exactly on a threshold or one step below it. Only a width of 380 clocks (3800 ticks) coincides with a table entry, so the stimulus table places answers at 379 and 380 clocks. It also places answers just under the first transmit entry and at or above the last one. The bench acts as the target. It watches for the host to release the wire, then pulls the wire low for an exact number of clocks, so every expected width and index is known in advance.

// File: rtl/sd_pkg.sv
package sd_pkg;

    localparam int REF_MHZ = 60;
    localparam int TX_N    = 20;
    localparam int RX_N    = 16;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_NO_FALL = 3'd1,
        ERR_NO_RISE = 3'd2,
        ERR_RANGE   = 3'd3,
        ERR_STUCK   = 3'd4
    } sd_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_HIGH,
        ST_REQ_LOW,
        ST_DRIVE_HIGH,
        ST_WAIT_FALL,
        ST_WAIT_RISE,
        ST_CLASSIFY,
        ST_DONE
    } sd_state_e;

    // Transmit profile thresholds in 60 MHz ticks, ascending
    function automatic int tx_thr(input int i);
        case (i)
            0: return 914;     1: return 1129;    2: return 1335;    3: return 1541;
            4: return 1747;    5: return 1952;    6: return 2157;    7: return 2465;
            8: return 2877;    9: return 3288;   10: return 3800;   11: return 4418;
           12: return 5136;   13: return 6059;   14: return 7189;   15: return 8524;
           16: return 10066;  17: return 11814;  18: return 13867;  default: return 16988;
        endcase
    endfunction

    // Receive profile thresholds in 60 MHz ticks, ascending
    function automatic int rx_thr(input int i);
        case (i)
            0: return 853;     1: return 1101;    2: return 1347;    3: return 1592;
            4: return 1837;    5: return 2202;    6: return 2694;    7: return 3303;
            8: return 4042;    9: return 4897;   10: return 5998;   11: return 7346;
           12: return 9055;   13: return 11257;  14: return 13952;  default: return 17919;
        endcase
    endfunction

endpackage

// File: rtl/sd_line_sync.sv
module sd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level,
    output logic fell,
    output logic rose
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign fell  = prev & ~chain[STAGES-1];
    assign rose  = ~prev & chain[STAGES-1];
endmodule

// File: rtl/sd_rate_pick.sv
module sd_rate_pick #(
    parameter int N     = 20,
    parameter int LW    = 20,
    parameter bit IS_RX = 1'b0,
    localparam int IW   = $clog2(N)
) (
    input  logic [LW-1:0] len,
    output logic [IW-1:0] idx,
    output logic          ok
);
    import sd_pkg::*;

    logic [N-1:0] meets;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        if (IS_RX) begin : g_rx
            assign meets[g] = (32'(len) >= rx_thr(g));
        end else begin : g_tx
            assign meets[g] = (32'(len) >= tx_thr(g));
        end
    end

    // highest met entry wins: equivalent to a downward scan
    logic any;
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (meets[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

    assign ok = any && (idx != IW'(N - 1));
endmodule

// File: rtl/sd_seq.sv
module sd_seq #(
    parameter int TW         = 16,
    parameter int REQ_CYCLES = 64,
    parameter int HI_CYCLES  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          line_lvl,
    input  logic          line_fell,
    input  logic          line_rose,
    input  logic [TW-1:0] hi_timeout,
    input  logic [TW-1:0] resp_timeout,
    input  logic          range_ok,
    output logic          line_oe,
    output logic          line_out,
    output logic [TW-1:0] len_raw,
    output logic          start_stb,
    output logic          cls_stb,
    output logic          done,
    output logic          valid,
    output logic [2:0]    err
);
    import sd_pkg::*;

    sd_state_e     st;
    logic [TW-1:0] tmr;
    logic [TW-1:0] fall_ts;

    assign start_stb = start && ((st == ST_IDLE) || (st == ST_DONE));
    assign cls_stb   = (st == ST_CLASSIFY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tmr      <= '0;
            fall_ts  <= '0;
            len_raw  <= '0;
            line_oe  <= 1'b0;
            line_out <= 1'b1;
            done     <= 1'b0;
            valid    <= 1'b0;
            err      <= ERR_NONE;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (start_stb) begin
                        st      <= ST_WAIT_HIGH;
                        tmr     <= '0;
                        done    <= 1'b0;
                        valid   <= 1'b0;
                        err     <= ERR_NONE;
                        len_raw <= '0;
                        line_oe <= 1'b0;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (line_lvl) begin
                        st       <= ST_REQ_LOW;
                        tmr      <= '0;
                        line_oe  <= 1'b1;
                        line_out <= 1'b0;
                    end else if (tmr >= hi_timeout) begin
                        st   <= ST_DONE;
                        err  <= ERR_STUCK;
                        done <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_REQ_LOW: begin
                    if (tmr == TW'(REQ_CYCLES - 1)) begin
                        st       <= ST_DRIVE_HIGH;
                        tmr      <= '0;
                        line_out <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_DRIVE_HIGH: begin
                    if (tmr == TW'(HI_CYCLES - 1)) begin
                        st      <= ST_WAIT_FALL;
                        tmr     <= '0;
                        line_oe <= 1'b0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_WAIT_FALL: begin
                    if (line_fell) begin
                        st      <= ST_WAIT_RISE;
                        fall_ts <= tmr;
                        tmr     <= tmr + 1'b1;
                    end else if (tmr >= resp_timeout) begin
                        st   <= ST_DONE;
                        err  <= ERR_NO_FALL;
                        done <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_WAIT_RISE: begin
                    if (line_rose) begin
                        st      <= ST_CLASSIFY;
                        len_raw <= tmr - fall_ts;
                    end else if (tmr >= resp_timeout) begin
                        st   <= ST_DONE;
                        err  <= ERR_NO_RISE;
                        done <= 1'b1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_CLASSIFY: begin
                    st    <= ST_DONE;
                    done  <= 1'b1;
                    valid <= range_ok;
                    err   <= range_ok ? ERR_NONE : ERR_RANGE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sd_detector.sv
module sd_detector #(
    parameter int CLK_MHZ     = 6,
    parameter int TW          = 16,
    parameter int REQ_CYCLES  = 64,
    parameter int HI_CYCLES   = 1,
    parameter int SYNC_STAGES = 2,
    localparam int SCALE      = sd_pkg::REF_MHZ / CLK_MHZ,
    localparam int LW         = TW + $clog2(SCALE + 1),
    localparam int TXW        = $clog2(sd_pkg::TX_N),
    localparam int RXW        = $clog2(sd_pkg::RX_N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           line_in,
    input  logic [TW-1:0]  hi_timeout,
    input  logic [TW-1:0]  resp_timeout,
    output logic           line_oe,
    output logic           line_out,
    output logic [LW-1:0]  sync_len,
    output logic [TXW-1:0] tx_idx,
    output logic [RXW-1:0] rx_idx,
    output logic [LW-1:0]  wait64,
    output logic [LW-1:0]  wait150,
    output logic           speed_valid,
    output logic           done,
    output logic [2:0]     err
);
    import sd_pkg::*;

    localparam int DIV64  = 3 * SCALE * 128 / 64;
    localparam int DIV150 = 3 * SCALE * 128 / 150;

    logic          lvl, fell, rose;
    logic [TW-1:0] len_raw;
    logic          start_stb, cls_stb;
    logic          tx_ok, rx_ok;
    logic [TXW-1:0] tx_pick;
    logic [RXW-1:0] rx_pick;
    logic [LW-1:0] len_scaled, q64, q150;

    sd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .line_in(line_in),
        .level(lvl), .fell(fell), .rose(rose)
    );

    sd_seq #(.TW(TW), .REQ_CYCLES(REQ_CYCLES), .HI_CYCLES(HI_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .line_lvl(lvl), .line_fell(fell), .line_rose(rose),
        .hi_timeout(hi_timeout), .resp_timeout(resp_timeout),
        .range_ok(tx_ok && rx_ok),
        .line_oe(line_oe), .line_out(line_out), .len_raw(len_raw),
        .start_stb(start_stb), .cls_stb(cls_stb),
        .done(done), .valid(speed_valid), .err(err)
    );

    assign len_scaled = LW'(len_raw) * LW'(SCALE);

    sd_rate_pick #(.N(TX_N), .LW(LW), .IS_RX(1'b0)) u_tx (
        .len(len_scaled), .idx(tx_pick), .ok(tx_ok)
    );
    sd_rate_pick #(.N(RX_N), .LW(LW), .IS_RX(1'b1)) u_rx (
        .len(len_scaled), .idx(rx_pick), .ok(rx_ok)
    );

    assign q64  = len_scaled / LW'(DIV64);
    assign q150 = len_scaled / LW'(DIV150);

    always_ff @(posedge clk) begin
        if (rst || start_stb) begin
            sync_len <= '0;
            tx_idx   <= '0;
            rx_idx   <= '0;
            wait64   <= '0;
            wait150  <= '0;
        end else if (cls_stb) begin
            sync_len <= len_scaled;
            if (tx_ok && rx_ok) begin
                tx_idx  <= tx_pick;
                rx_idx  <= rx_pick;
                wait64  <= (q64  > LW'(6)) ? q64  - LW'(6) : '0;
                wait150 <= (q150 > LW'(7)) ? q150 - LW'(7) : '0;
            end
        end
    end
endmodule

// File: rtl/sd_detector_chk.sv
module sd_detector_chk #(
    parameter int LW  = 20,
    parameter int TXW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           line_oe,
    input logic           line_out,
    input logic [LW-1:0]  sync_len,
    input logic [TXW-1:0] tx_idx,
    input logic           speed_valid,
    input logic           done,
    input logic [2:0]     err
);
    // R2: driving low is always followed by another driven cycle
    assert_no_release_from_low_R2: assert property (@(posedge clk) disable iff (rst)
        (line_oe && !line_out) |=> line_oe);

    // R10: a finished result is held until a new start
    assert_result_held_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(sync_len) && $stable(tx_idx) && $stable(err)));

    // R10: wire stays released once finished
    assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !line_oe);

    // R8: success and an error code never coexist
    assert_valid_no_err_R8: assert property (@(posedge clk) disable iff (rst)
        speed_valid |-> (err == 3'd0 && done));

    // R6: a valid result never carries the last transmit entry
    assert_tx_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        speed_valid |-> (tx_idx < TXW'(19)));
endmodule

bind sd_detector sd_detector_chk #(.LW(LW), .TXW(TXW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .line_oe(line_oe), .line_out(line_out),
    .sync_len(sync_len), .tx_idx(tx_idx), .speed_valid(speed_valid),
    .done(done), .err(err)
);

// File: tb/tb_sd_detector.sv
module tb_sd_detector;
    localparam int TW  = 16;
    localparam int LW  = 20;
    localparam int REQ = 64;
    localparam int NV  = 10;

    // answer width (clocks), tx, rx, wait64, wait150, err
    localparam int V_W   [NV] = '{92, 114, 150, 379, 380, 500, 1000, 1390, 91, 1700};
    localparam int V_TX  [NV] = '{0, 1, 2, 9, 10, 11, 15, 18, 0, 0};
    localparam int V_RX  [NV] = '{0, 1, 2, 7, 7, 9, 12, 13, 0, 0};
    localparam int V_W64 [NV] = '{9, 13, 19, 57, 57, 77, 160, 225, 0, 0};
    localparam int V_W150[NV] = '{29, 38, 53, 144, 145, 193, 393, 549, 0, 0};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 3, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tgt_low = 1'b0;
    logic [TW-1:0] hi_timeout = 16'd100;
    logic [TW-1:0] resp_timeout = 16'd4000;
    logic line_oe, line_out, speed_valid, done;
    logic [LW-1:0] sync_len, wait64, wait150;
    logic [4:0] tx_idx;
    logic [3:0] rx_idx;
    logic [2:0] err;
    logic line;

    int n_checks = 0;
    int n_errs = 0;

    always #2 clk = ~clk;

    assign line = line_oe ? line_out : ~tgt_low;

    sd_detector dut (
        .clk(clk), .rst(rst), .start(start), .line_in(line),
        .hi_timeout(hi_timeout), .resp_timeout(resp_timeout),
        .line_oe(line_oe), .line_out(line_out), .sync_len(sync_len),
        .tx_idx(tx_idx), .rx_idx(rx_idx), .wait64(wait64), .wait150(wait150),
        .speed_valid(speed_valid), .done(done), .err(err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000 && !done; k++) tick(1);
    endtask

    // mode 0: normal answer, 1: no answer, 2: never releases
    task automatic measure(input int w, input int mode, input bit chk_req);
        int lo_cnt;
        int hi_cnt;
        lo_cnt = 0;
        hi_cnt = 0;
        pulse_start();
        for (int k = 0; k < 1000 && !(line_oe && !line_out); k++) tick(1);
        while (line_oe && !line_out) begin lo_cnt++; tick(1); end
        while (line_oe && line_out) begin hi_cnt++; tick(1); end
        if (chk_req) begin
            check("R2 request low cycles", lo_cnt, REQ);
            check("R2 drive-high cycles", hi_cnt, 1);
        end
        tick(8);
        if (mode != 1) begin
            tgt_low = 1'b1;
            if (mode == 0) begin
                tick(w);
                tgt_low = 1'b0;
            end
        end
        wait_done();
        tgt_low = 1'b0;
    endtask

    initial begin
        tick(3);
        check("R11 reset line_oe", int'(line_oe), 0);
        check("R11 reset done", int'(done), 0);
        check("R11 reset valid", int'(speed_valid), 0);
        check("R11 reset err", int'(err), 0);
        rst = 1'b0;
        tick(2);

        for (int v = 0; v < NV; v++) begin
            measure(V_W[v], 0, v == 0);
            check("R10 done", int'(done), 1);
            check("R3 sync_len", int'(sync_len), V_W[v] * 10);
            if (V_ERR[v] == 0) begin
                check("R6 tx_idx", int'(tx_idx), V_TX[v]);
                check("R7 rx_idx", int'(rx_idx), V_RX[v]);
                check("R9 wait64", int'(wait64), V_W64[v]);
                check("R9 wait150", int'(wait150), V_W150[v]);
                check("R10 speed_valid", int'(speed_valid), 1);
                check("R8 err", int'(err), 0);
            end else begin
                check("R8 err range", int'(err), 3);
                check("R8 valid low", int'(speed_valid), 0);
                check("R8 tx zero", int'(tx_idx), 0);
                check("R8 wait64 zero", int'(wait64), 0);
            end
        end

        // R10: results held while the wire toggles after done
        measure(500, 0, 1'b0);
        tgt_low = 1'b1;
        tick(40);
        tgt_low = 1'b0;
        tick(40);
        check("R10 held tx_idx", int'(tx_idx), 11);
        check("R10 held sync_len", int'(sync_len), 5000);
        check("R10 held line_oe", int'(line_oe), 0);
        check("R10 held valid", int'(speed_valid), 1);

        // R10: start clears done and valid on the next clock
        pulse_start();
        check("R10 start clears done", int'(done), 0);
        check("R10 start clears valid", int'(speed_valid), 0);
        wait_done();

        // R4: target never answers
        measure(0, 1, 1'b0);
        check("R4 no fall err", int'(err), 1);
        check("R4 sync_len zero", int'(sync_len), 0);
        check("R4 valid low", int'(speed_valid), 0);

        // R5: target pulls low and holds
        measure(0, 2, 1'b0);
        check("R5 no rise err", int'(err), 2);
        check("R5 valid low", int'(speed_valid), 0);

        // R1: wire stuck low before the request
        tgt_low = 1'b1;
        pulse_start();
        wait_done();
        check("R1 stuck err", int'(err), 4);
        check("R1 never drove", int'(line_oe), 0);
        tgt_low = 1'b0;
        tick(4);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule